// File: doc/BRIEF.md
# I2C Bus Error Guard

This block watches the two wires of an I2C bus and catches START and STOP conditions that show up in the middle of a frame, where the protocol does not allow them. A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Both lines pass through a synchronizer before any edge is judged.

The transfer sequencer feeds the block two things: the device's current role, and the bit position inside the frame. Positions 0 to 7 are the eight address or data bits and position 8 is the acknowledge bit. Any value above 8 means the acknowledge has completed and the bus sits between frames.

A condition is treated as an error only when all three of these hold:
- it falls on a position from 0 to 8;
- the device is a master or an addressed slave;
- it is a real START or STOP, not a data edge.

On an error the block does four things:
- it sends the sequencer a one-cycle abort pulse, which returns the sequencer to the not-addressed slave state;
- it lets go of both open-drain line drivers;
- it raises an interrupt flag;
- it loads the status code 00H.

The drivers stay released until a new transfer is requested. The flag and the status stay latched until software clears them.

Top module: `i2c_buserr_guard`

## Requirements
- R1: A START (SDA falls while SCL is high) at bit position 0..8, with role master (2'b10) or addressed slave (2'b01), produces exactly one abort pulse. The pulse is registered and appears on the third rising clock edge after the raw line change, which covers two synchronizer stages and one output register.
- R2: A STOP (SDA rises while SCL is high) under the same role and position conditions produces the same single abort pulse with the same latency.
- R3: A START or STOP while the bit position is above 8 (between frames) is not an error. No abort occurs, and the interrupt flag and status code do not change.
- R4: When the role is idle / not-addressed slave (2'b00) or the reserved code (2'b11), a START or STOP at any position is ignored. No abort occurs, the interrupt stays low and the line drivers keep following their requests.
- R5: In the cycle the abort pulse is high, both driver enables `sda_oe` and `scl_oe` are low (lines released), whatever the drive requests are.
- R6: In the cycle the abort pulse is high, `irq` is 1 and `status` is 8'h00.
- R7: `irq` and `status` hold their values until `irq_clr` is asserted. One cycle after `irq_clr`, `irq` is 0 and `status` returns to the idle code 8'hF8. A new error in that same cycle wins over the clear.
- R8: After an error, both driver enables stay low until `xfer_req` is asserted. From the next cycle on, each enable equals its request input, registered by one cycle.
- R9: An SDA edge while SCL is low is ordinary data and never causes an abort.
- R10: After synchronous reset, `abort_o`, `irq`, `sda_oe` and `scl_oe` are 0 and `status` is 8'hF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_i | input | 1 | Raw SDA line level |
| scl_i | input | 1 | Raw SCL line level |
| role_i | input | 2 | Current role: 00 idle, 01 addressed slave, 10 master, 11 reserved |
| pos_i | input | 4 | Bit position in frame: 0..7 data, 8 acknowledge, above 8 between frames |
| sda_lo_req | input | 1 | Sequencer request to pull SDA low |
| scl_lo_req | input | 1 | Sequencer request to pull SCL low |
| xfer_req | input | 1 | New transfer requested; re-enables the drivers |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| abort_o | output | 1 | One-cycle abort pulse; forces the not-addressed slave state |
| sda_oe | output | 1 | Open-drain SDA pull-down enable |
| scl_oe | output | 1 | Open-drain SCL pull-down enable |
| irq | output | 1 | Interrupt flag |
| status | output | 8 | Status code (00H on bus error) |

## Verification
A wrong synchronizer or detection state shows at the ports in one of two ways. An abort pulse may arrive on a different edge than the third one after the line change. Or a data edge with SCL low, or a condition under an idle role, may produce an abort. Both are visible within five cycles of the stimulus.

A wrong release-hold state shows in the first sampled cycle after an error, or after `xfer_req`: a driver enable pulls a line when it should not, or stays released when it should follow its request. A stuck interrupt or status register shows one cycle after `irq_clr`.

// File: rtl/i2c_buserr_pkg.sv
package i2c_buserr_pkg;
  typedef enum logic [1:0] {
    ROLE_NAS = 2'b00,
    ROLE_ASL = 2'b01,
    ROLE_MST = 2'b10,
    ROLE_RSV = 2'b11
  } role_e;

  function automatic logic role_active(role_e r);
    return (r == ROLE_ASL) || (r == ROLE_MST);
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_i,
  input  logic scl_i,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;
  logic [LINES-1:0] raw;
  logic [LINES-1:0] now;
  logic [LINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] shreg;
      logic              last;
      always_ff @(posedge clk) begin
        if (rst) begin
          shreg <= '1;
          last  <= 1'b1;
        end else begin
          shreg <= {shreg[STAGES-2:0], raw[g]};
          last  <= shreg[STAGES-1];
        end
      end
      assign now[g]  = shreg[STAGES-1];
      assign prev[g] = last;
    end
  endgenerate

  // index 0 = SDA, index 1 = SCL
  always_comb begin
    start_o = prev[0] & ~now[0] & now[1] & prev[1];
    stop_o  = ~prev[0] & now[0] & now[1] & prev[1];
  end
endmodule

// File: rtl/i2c_pos_check.sv
module i2c_pos_check
  import i2c_buserr_pkg::*;
#(
  parameter int POS_W   = 4,
  parameter int ACK_POS = 8
) (
  input  logic             start_i,
  input  logic             stop_i,
  input  role_e            role_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             err_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(ACK_POS);

  logic in_frame;
  always_comb begin
    in_frame = (pos_i <= LAST_POS);
    err_o    = (start_i | stop_i) & in_frame & role_active(role_i);
  end
endmodule

// File: rtl/i2c_err_resp.sv
module i2c_err_resp #(
  parameter int              STAT_W      = 8,
  parameter logic [STAT_W-1:0] IDLE_STATUS = 8'hF8,
  parameter logic [STAT_W-1:0] ERR_STATUS  = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_i,
  input  logic              irq_clr,
  input  logic              xfer_req,
  input  logic              sda_lo_req,
  input  logic              scl_lo_req,
  output logic              abort_o,
  output logic              irq,
  output logic [STAT_W-1:0] status,
  output logic              sda_oe,
  output logic              scl_oe
);
  logic hold_q, hold_d;

  always_comb begin
    if (err_i)         hold_d = 1'b1;
    else if (xfer_req) hold_d = 1'b0;
    else               hold_d = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      abort_o <= 1'b0;
      irq     <= 1'b0;
      status  <= IDLE_STATUS;
      sda_oe  <= 1'b0;
      scl_oe  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      abort_o <= err_i;
      sda_oe  <= sda_lo_req & ~hold_d;
      scl_oe  <= scl_lo_req & ~hold_d;
      if (err_i) begin
        irq    <= 1'b1;
        status <= ERR_STATUS;
      end else if (irq_clr) begin
        irq    <= 1'b0;
        status <= IDLE_STATUS;
      end
    end
  end

  // R5
  release_on_abort_chk: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (!sda_oe && !scl_oe));
  // R6
  flag_on_abort_chk: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (irq && status == ERR_STATUS));
  // R7
  irq_latched_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> (irq && $stable(status)));
  // R8
  stay_released_chk: assert property (@(posedge clk) disable iff (rst)
    (abort_o && !xfer_req) |=> (!sda_oe && !scl_oe));
endmodule

// File: rtl/i2c_buserr_guard.sv
module i2c_buserr_guard
  import i2c_buserr_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                POS_W       = 4,
  parameter int                ACK_POS     = 8,
  parameter int                STAT_W      = 8,
  parameter logic [STAT_W-1:0] IDLE_STATUS = 8'hF8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic [1:0]        role_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              sda_lo_req,
  input  logic              scl_lo_req,
  input  logic              xfer_req,
  input  logic              irq_clr,
  output logic              abort_o,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              irq,
  output logic [STAT_W-1:0] status
);
  logic  start_w, stop_w, err_w;
  role_e role_w;

  assign role_w = role_e'(role_i);

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sda_i(sda_i), .scl_i(scl_i),
    .start_o(start_w), .stop_o(stop_w)
  );

  i2c_pos_check #(.POS_W(POS_W), .ACK_POS(ACK_POS)) u_pos (
    .start_i(start_w), .stop_i(stop_w), .role_i(role_w), .pos_i(pos_i),
    .err_o(err_w)
  );

  i2c_err_resp #(.STAT_W(STAT_W), .IDLE_STATUS(IDLE_STATUS),
                 .ERR_STATUS('0)) u_resp (
    .clk(clk), .rst(rst), .err_i(err_w), .irq_clr(irq_clr),
    .xfer_req(xfer_req), .sda_lo_req(sda_lo_req), .scl_lo_req(scl_lo_req),
    .abort_o(abort_o), .irq(irq), .status(status),
    .sda_oe(sda_oe), .scl_oe(scl_oe)
  );

  // R4
  role_gate_chk: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> ($past(role_i) == 2'b01 || $past(role_i) == 2'b10));
  // R3
  pos_gate_chk: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> ($past(pos_i) <= POS_W'(ACK_POS)));
endmodule

// File: tb/i2c_buserr_guard_tb_top.sv
module i2c_buserr_guard_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sda_i = 1'b1, scl_i = 1'b1;
  logic [1:0] role_i = 2'b00;
  logic [3:0] pos_i = 4'd15;
  logic sda_lo_req = 1'b0, scl_lo_req = 1'b0, xfer_req = 1'b0, irq_clr = 1'b0;
  logic abort_o, sda_oe, scl_oe, irq;
  logic [7:0] status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_buserr_guard dut_i (
    .clk(clk), .rst(rst), .sda_i(sda_i), .scl_i(scl_i), .role_i(role_i),
    .pos_i(pos_i), .sda_lo_req(sda_lo_req), .scl_lo_req(scl_lo_req),
    .xfer_req(xfer_req), .irq_clr(irq_clr), .abort_o(abort_o),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .irq(irq), .status(status)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ctype: 0 START, 1 STOP, 2 SDA fall with SCL low, 3 SDA rise with SCL low
  function automatic bit exp_err(int ctype, logic [1:0] role, logic [3:0] pos);
    return (ctype < 2) && (role == 2'b01 || role == 2'b10) && (pos <= 4'd8);
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prep(int ctype);
    role_i = 2'b00;
    scl_i = 1'b0; cyc(2);
    sda_i = (ctype == 0 || ctype == 2) ? 1'b1 : 1'b0; cyc(2);
    scl_i = (ctype < 2) ? 1'b1 : 1'b0; cyc(4);
  endtask

  task automatic recover();
    xfer_req = 1'b1; irq_clr = 1'b1; cyc(1);
    xfer_req = 1'b0; irq_clr = 1'b0;
    chk("R7 irq cleared", irq, 0);
    chk("R7 status idle", status, 8'hF8);
    chk("R8 sda follows", sda_oe, sda_lo_req);
    chk("R8 scl follows", scl_oe, scl_lo_req);
  endtask

  task automatic trial(int ctype, logic [1:0] role, logic [3:0] pos,
                       logic sreq, logic creq);
    bit e;
    int pulses = 0;
    prep(ctype);
    sda_lo_req = sreq; scl_lo_req = creq;
    role_i = role; pos_i = pos; cyc(1);
    e = exp_err(ctype, role, pos);
    sda_i = ~sda_i;
    for (int k = 1; k <= 5; k++) begin
      cyc(1);
      if (abort_o) pulses++;
      if (k == 3) begin
        chk(ctype == 1 ? "R2 abort latency" : (ctype == 0 ? "R1 abort latency" : "R9 no abort"),
            abort_o, e);
        if (e) begin
          chk("R5 sda released", sda_oe, 0);
          chk("R5 scl released", scl_oe, 0);
          chk("R6 irq set", irq, 1);
          chk("R6 status 00", status, 8'h00);
        end
      end
    end
    chk(e ? "R1 single pulse" : "R4 R3 no pulse", pulses, e ? 1 : 0);
    if (e) begin
      cyc(2);
      chk("R7 irq held", irq, 1);
      chk("R7 status held", status, 8'h00);
      chk("R8 sda still released", sda_oe, 0);
      chk("R8 scl still released", scl_oe, 0);
      recover();
    end else begin
      chk("R4 irq low", irq, 0);
      chk("R3 status unchanged", status, 8'hF8);
      chk("R4 sda follows", sda_oe, sreq);
      chk("R4 scl follows", scl_oe, creq);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R10 abort", abort_o, 0);
    chk("R10 irq", irq, 0);
    chk("R10 status", status, 8'hF8);
    chk("R10 sda_oe", sda_oe, 0);
    chk("R10 scl_oe", scl_oe, 0);
    // directed corners
    trial(0, 2'b10, 4'd8, 1, 1);   // R1 START at acknowledge
    trial(1, 2'b01, 4'd0, 1, 1);   // R2 STOP at first bit
    trial(0, 2'b10, 4'd9, 1, 0);   // R3 just past ack
    trial(1, 2'b11, 4'd3, 0, 1);   // R4 reserved role
    trial(0, 2'b00, 4'd5, 1, 1);   // R4 idle role
    trial(2, 2'b10, 4'd4, 1, 1);   // R9 data edge
    trial(3, 2'b01, 4'd7, 1, 0);   // R9 data edge
    // R7 error wins over clear in the same cycle
    prep(0); role_i = 2'b10; pos_i = 4'd2; cyc(1);
    sda_i = 1'b0; cyc(2); irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    chk("R7 error beats clear irq", irq, 1);
    chk("R7 error beats clear status", status, 8'h00);
    recover();
    for (int i = 0; i < 60; i++) begin
      trial($urandom_range(0, 3), 2'($urandom_range(0, 3)),
            4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)));
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule